// File: doc/BRIEF.md
# Dual-Line Device Interrupt Register Block

This block gathers ten event sources of a USB-style device controller into one set of sticky status bits and turns them into two interrupt requests. Hardware raises a status bit with a one-cycle pulse on its event input. The bit then stays set until software clears it by writing a one to the matching bit of a write-one-to-clear register. An enable register selects which pending bits may raise an interrupt.

Every enabled pending event goes to the low-priority request line by default. A two-bit routing register can move the start-of-frame event, the fast-endpoint summary event, or both, to the high-priority line. A moved event is then removed from the low-priority line.

The two endpoint summary bits (fast and slow) are also fed by level inputs from the per-endpoint interrupt logic. While such a level input is high, the summary bit sets again on every cycle. Software therefore has to clear the per-endpoint status before the summary bit will stay clear. Software reaches the block through a simple 32-bit register bus. Writes take effect on the clock edge, and reads are combinational.

Top module: `devirq_regblock`

## Requirements
- R1: After reset the status, enable and routing registers read zero, and both irq_lp and irq_hp are low.
- R2: A high level on evt_pulse[i] during a clock edge sets status bit i, and the bit then holds until it is cleared. Bit map: 0 frame, 1 fast endpoint, 2 slow endpoint, 3 device state, 4 command empty, 5 data full, 6 rx packet end, 7 tx packet end, 8 endpoints realized, 9 error.
- R3: The enable register at byte offset 0x4 is readable and writable in bits 9:0. Its bits 31:10 read as zero.
- R4: Writing at byte offset 0x8 clears every status bit whose data bit is 1 and leaves the others unchanged. Reads at offset 0x8 return zero.
- R5: When an event pulse or a summary input and a clear hit the same bit in the same cycle, the bit ends up set.
- R6: irq_lp is high one cycle after some status bit is set, enabled and not routed to the high line. It is low one cycle after no such bit exists.
- R7: Routing register bit 0 moves the frame event (status bit 0), and bit 1 moves the fast endpoint event (status bit 1), onto irq_hp only. irq_hp is the registered OR of the enabled, pending, moved bits.
- R8: While ep_summary[0] is high, status bit 1 cannot be cleared. While ep_summary[1] is high, status bit 2 cannot be cleared. Once the input drops, a clear takes effect.
- R9: Writes to the status register at offset 0x0 have no effect, and its bits 31:10 read as zero.
- R10: The routing register at offset 0xC reads back bits 1:0 as written, and its bits 31:2 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| evt_pulse | input | 10 | Event pulses, one per status bit |
| ep_summary | input | 2 | Pending levels: bit 0 fast endpoint, bit 1 slow endpoint |
| irq_lp | output | 1 | Low-priority interrupt request |
| irq_hp | output | 1 | High-priority interrupt request |

## Verification
The bench sweeps every event bit against both enable values and all four routing settings. A design that leaves a moved event on the low line, or that moves the wrong bit, shows up as the wrong request line. A same-cycle pulse and clear on one bit catches a design in which the clear wins and an event is lost. A held summary input catches a summary bit that can be cleared while per-endpoint work is still pending. Writes of all ones to the status, enable and routing offsets catch reserved bits that read back, and a status register that software can write.

// File: rtl/devirq_pkg.sv
package devirq_pkg;
  localparam int EV_FRAME     = 0;
  localparam int EV_EP_FAST   = 1;
  localparam int EV_EP_SLOW   = 2;
  localparam int EV_DEV_STATE = 3;
  localparam int EV_CMD_EMPTY = 4;
  localparam int EV_DATA_FULL = 5;
  localparam int EV_RX_END    = 6;
  localparam int EV_TX_END    = 7;
  localparam int EV_REALIZED  = 8;
  localparam int EV_ERROR     = 9;
  localparam int EV_COUNT     = 10;

  localparam int ROUTE_W = 2;

  // word indices of the registers (byte address / 4)
  localparam int WRD_STATUS = 0;
  localparam int WRD_ENABLE = 1;
  localparam int WRD_CLEAR  = 2;
  localparam int WRD_ROUTE  = 3;

  // which status bits the routing register moves to the high line
  function automatic logic [EV_COUNT-1:0] hp_select(input logic [ROUTE_W-1:0] route);
    logic [EV_COUNT-1:0] m;
    m = '0;
    m[EV_FRAME]   = route[0];
    m[EV_EP_FAST] = route[1];
    return m;
  endfunction

  // hardware set vector: pulses plus the endpoint summary levels
  function automatic logic [EV_COUNT-1:0] set_merge(input logic [EV_COUNT-1:0] pulse,
                                                    input logic [1:0] summary);
    logic [EV_COUNT-1:0] s;
    s = pulse;
    s[EV_EP_FAST] = s[EV_EP_FAST] | summary[0];
    s[EV_EP_SLOW] = s[EV_EP_SLOW] | summary[1];
    return s;
  endfunction
endpackage

// File: rtl/devirq_status.sv
module devirq_status #(
  parameter int NUM_EVT = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] set_vec,
  input  logic [NUM_EVT-1:0] clr_vec,
  output logic [NUM_EVT-1:0] status
);
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) status[i] <= 1'b0;
      else if (set_vec[i]) status[i] <= 1'b1;
      else if (clr_vec[i]) status[i] <= 1'b0;
    end
  end

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec == '0 && clr_vec == '0) |=> status == $past(status));
  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec & clr_vec) != '0) |=> ((status & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec)));
  // R4
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((status & $past(clr_vec & ~set_vec)) == '0));
endmodule

// File: rtl/devirq_regif.sv
module devirq_regif
  import devirq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int NUM_EVT = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_EVT-1:0] status,
  output logic [NUM_EVT-1:0] enable,
  output logic [NUM_EVT-1:0] hp_mask,
  output logic [NUM_EVT-1:0] clr_vec
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]   word;
  logic [ROUTE_W-1:0] route;
  logic               wr_enable, wr_clear, wr_route;
  logic               unused_bits;

  assign word        = bus_addr[ADDR_W-1:2];
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:NUM_EVT]};
  assign wr_enable   = bus_we && (word == IDX_W'(WRD_ENABLE));
  assign wr_clear    = bus_we && (word == IDX_W'(WRD_CLEAR));
  assign wr_route    = bus_we && (word == IDX_W'(WRD_ROUTE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable <= '0;
      route  <= '0;
    end else begin
      if (wr_enable) enable <= bus_wdata[NUM_EVT-1:0];
      if (wr_route)  route  <= bus_wdata[ROUTE_W-1:0];
    end
  end

  assign clr_vec = wr_clear ? bus_wdata[NUM_EVT-1:0] : '0;
  assign hp_mask = hp_select(route);

  always_comb begin
    bus_rdata = '0;
    if (word == IDX_W'(WRD_STATUS))      bus_rdata = DATA_W'(status);
    else if (word == IDX_W'(WRD_ENABLE)) bus_rdata = DATA_W'(enable);
    else if (word == IDX_W'(WRD_ROUTE))  bus_rdata = DATA_W'(route);
  end

  // R4
  clear_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |-> bus_we);
  // R3
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_enable) |-> $stable(enable));
endmodule

// File: rtl/devirq_route.sv
module devirq_route #(
  parameter int NUM_EVT = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] status,
  input  logic [NUM_EVT-1:0] enable,
  input  logic [NUM_EVT-1:0] hp_mask,
  output logic               irq_lp,
  output logic               irq_hp
);
  logic [NUM_EVT-1:0] active;
  logic               lp_next, hp_next;

  assign active  = status & enable;
  assign lp_next = |(active & ~hp_mask);
  assign hp_next = |(active & hp_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_lp <= 1'b0;
      irq_hp <= 1'b0;
    end else begin
      irq_lp <= lp_next;
      irq_hp <= hp_next;
    end
  end

  // R7
  hp_needs_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hp |-> $past(hp_mask != '0));
  // R6
  lp_needs_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lp |-> $past((status & enable) != '0));
endmodule

// File: rtl/devirq_regblock.sv
module devirq_regblock
  import devirq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [EV_COUNT-1:0] evt_pulse,
  input  logic [1:0]          ep_summary,
  output logic                irq_lp,
  output logic                irq_hp
);
  logic [EV_COUNT-1:0] status, enable, hp_mask, clr_vec, set_vec;

  assign set_vec = set_merge(evt_pulse, ep_summary);

  devirq_regif #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_EVT(EV_COUNT)) u_regif (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .status(status),
    .enable(enable), .hp_mask(hp_mask), .clr_vec(clr_vec));

  devirq_status #(.NUM_EVT(EV_COUNT)) u_status (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .status(status));

  devirq_route #(.NUM_EVT(EV_COUNT)) u_route (
    .clk(clk), .rst_n(rst_n), .status(status), .enable(enable), .hp_mask(hp_mask),
    .irq_lp(irq_lp), .irq_hp(irq_hp));

  // R8
  summary_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ep_summary[0] |=> status[EV_EP_FAST]);
  // R8
  summary_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ep_summary[1] |=> status[EV_EP_SLOW]);
endmodule

// File: tb/devirq_regblock_test.sv
`timescale 1ns/1ps
module devirq_regblock_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [9:0]  evt_pulse = '0;
  logic [1:0]  ep_summary = '0;
  logic        irq_lp, irq_hp;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  devirq_regblock uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
    .ep_summary(ep_summary), .irq_lp(irq_lp), .irq_hp(irq_hp));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [9:0] m);
    @(negedge clk);
    evt_pulse = m;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic summary_line;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary_line();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(4'h0, v); check("R1 status", v, 0);
    rd(4'h4, v); check("R1 enable", v, 0);
    rd(4'hC, v); check("R1 route", v, 0);
    check("R1 irq_lp", {31'b0, irq_lp}, 0);
    check("R1 irq_hp", {31'b0, irq_hp}, 0);

    // R3 enable RW, reserved bits read zero
    wr(4'h4, 32'hFFFF_FFFF); rd(4'h4, v); check("R3 enable all", v, 32'h3FF);
    wr(4'h4, 32'h0000_0155); rd(4'h4, v); check("R3 enable pattern", v, 32'h155);
    // R10 route readback
    wr(4'hC, 32'hFFFF_FFFF); rd(4'hC, v); check("R10 route all", v, 32'h3);
    wr(4'hC, 32'h2); rd(4'hC, v); check("R10 route pattern", v, 32'h2);
    // R9 status not writable
    wr(4'h4, 0); wr(4'h0, 32'hFFFF_FFFF); rd(4'h0, v); check("R9 status write ignored", v, 0);

    // R2 R6 R7 sweep: every bit x enable x route
    for (int i = 0; i < 10; i++) begin
      for (int e = 0; e < 2; e++) begin
        for (int p = 0; p < 4; p++) begin
          bit moved, exp_lp, exp_hp;
          wr(4'h4, e ? (32'h1 << i) : 32'h0);
          wr(4'hC, p);
          wr(4'h8, 32'h3FF);
          @(negedge clk);
          check("R6 lp idle", {31'b0, irq_lp}, 0);
          check("R7 hp idle", {31'b0, irq_hp}, 0);
          pulse(10'(1 << i));
          rd(4'h0, v); check("R2 status bit set", v, 32'h1 << i);
          @(negedge clk);
          moved  = (i == 0 && p[0]) || (i == 1 && p[1]);
          exp_lp = e && !moved;
          exp_hp = e && moved;
          check("R6 lp routed", {31'b0, irq_lp}, {31'b0, exp_lp});
          check("R7 hp routed", {31'b0, irq_hp}, {31'b0, exp_hp});
          repeat (2) @(negedge clk);
          rd(4'h0, v); check("R2 sticky", v, 32'h1 << i);
        end
      end
    end

    // R4 write-one-to-clear
    wr(4'hC, 0); wr(4'h4, 32'h3FF); wr(4'h8, 32'h3FF);
    pulse(10'h3FF);
    wr(4'h8, 32'h155); rd(4'h0, v); check("R4 partial clear", v, 32'h2AA);
    wr(4'h8, 32'h0);   rd(4'h0, v); check("R4 zero write no effect", v, 32'h2AA);
    rd(4'h8, v); check("R4 clear reads zero", v, 0);
    wr(4'h8, 32'h3FF); @(negedge clk);
    check("R6 lp drops", {31'b0, irq_lp}, 0);

    // R5 set wins over clear
    @(negedge clk);
    bus_addr = 4'h8; bus_wdata = 32'h8; bus_we = 1'b1; evt_pulse = 10'h8;
    @(negedge clk);
    bus_we = 1'b0; evt_pulse = '0;
    rd(4'h0, v); check("R5 set wins", v, 32'h8);
    wr(4'h8, 32'h3FF);

    // R8 summary levels hold the bits
    @(negedge clk); ep_summary = 2'b11;
    @(negedge clk);
    wr(4'h8, 32'h6); rd(4'h0, v); check("R8 summary holds", v, 32'h6);
    ep_summary = 2'b01;
    wr(4'h8, 32'h6); rd(4'h0, v); check("R8 slow releases", v, 32'h2);
    ep_summary = 2'b00;
    wr(4'h8, 32'h6); rd(4'h0, v); check("R8 fast releases", v, 0);

    finished = 1;
    summary_line();
    $finish;
  end
endmodule